// File: doc/BRIEF.md
# Quadword Block-Copy DMA Channel

This block is one DMA channel that copies a run of 128-bit quadwords from a source memory port to a destination memory port. Software programs it through four 32-bit registers on a small write/read configuration port: a control word, a quadword count, a source address and a target address. The target address is relative to a fixed destination window. The window base is a parameter and is added to the target register to form each write address.

Setting the start bit with a control write launches the copy. The sequencer then alternates one read beat and one write beat per quadword. Each beat uses a request/ready handshake, and the read data is held in a single quadword buffer between the two. When the last write is accepted, the channel zeroes the count register, drops the start bit and pulses its completion interrupt for one cycle. While the copy runs, the start bit reads as set, which makes it the busy flag. All register writes made during that time are discarded.

Top module: `qcopy_dma`

## Requirements
- R1: After reset, all four registers read zero, and `rdReq`, `wrReq` and `doneIrq` are low.
- R2: A register is selected by `cfgAddr` divided by 16, and the low four offset bits are ignored. Index 0 is control, 1 is quadword count, 2 is source address and 3 is target address. Indices 4 and above read as zero and are not writable.
- R3: A control write with bit 8 clear stores the written value and starts no memory traffic.
- R4: A start with count N issues exactly N reads and N writes, alternating and beginning with a read. Beat i reads `src + 16*i` and writes `DST_BASE + tgt + 16*i`, and each write carries the data returned by the read just before it.
- R5: A pending request keeps its address, and for writes its data, stable until its ready is seen.
- R6: In the cycle after the last write is accepted, `doneIrq` is high for exactly one cycle. After that cycle the count reads 0 and the control word reads back with only bit 8 cleared.
- R7: A start with a count of zero makes no memory request and raises `doneIrq` in the cycle right after the start write.
- R8: From the start write until completion, control bit 8 reads 1. Any register write made in that time, including a control write, has no effect.
- R9: The source and target registers keep their programmed values after a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | REG_AW | Register byte offset |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for `cfgAddr` (combinational) |
| rdReq | output | 1 | Source read request |
| rdAddr | output | ADDR_W | Source read byte address |
| rdReady | input | 1 | Source read accepted; `rdData` valid |
| rdData | input | DATA_W | Source read data |
| wrReq | output | 1 | Destination write request |
| wrAddr | output | ADDR_W | Destination write byte address |
| wrData | output | DATA_W | Destination write data |
| wrReady | input | 1 | Destination write accepted |
| doneIrq | output | 1 | One-cycle copy-complete interrupt |

## Verification
The bench targets six corner cases:
- **Zero count.** A wrong design would issue a stray beat or never raise the interrupt.
- **Single-quadword copy.** A wrong design would stop one beat early or late.
- **Long random-ready stalls.** A design that dropped its address or data while waiting would corrupt the copy.
- **Interrupt timing.** The bench checks that the interrupt lands exactly one cycle after the final write and lasts one cycle. A design with a sticky or mistimed pulse fails this.
- **Writes to every register mid-copy, including a control write of zero.** A design that let these through would change the length, move the pointers or abort the copy.
- **Readback after completion.** A design that walked the source or target registers, or cleared other control bits along with the start bit, is caught here.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

  localparam int REG_CTRL  = 0;
  localparam int REG_COUNT = 1;
  localparam int REG_SRC   = 2;
  localparam int REG_TGT   = 3;
  localparam int START_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // latch working pointers and beat count
    logic capture;  // read beat accepted: store quadword
    logic advance;  // write beat accepted: step pointers
    logic finish;   // clear count and start bit
  } dpStrobe_t;

endpackage

// File: rtl/qdma_ctrl.sv
module qdma_ctrl
  import qdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cntZero,
  input  logic       lastBeat,
  input  logic       rdReady,
  input  logic       wrReady,
  output logic       rdReq,
  output logic       wrReq,
  output logic       doneIrq,
  output logic       busy,
  output dpStrobe_t  strb
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          strb.load = 1'b1;
          stateD    = cntZero ? ST_FIN : ST_RD;
        end
      end
      ST_RD: begin
        if (rdReady) begin
          strb.capture = 1'b1;
          stateD       = ST_WR;
        end
      end
      ST_WR: begin
        if (wrReady) begin
          strb.advance = 1'b1;
          stateD       = lastBeat ? ST_FIN : ST_RD;
        end
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign rdReq   = (stateQ == ST_RD);
  assign wrReq   = (stateQ == ST_WR);
  assign doneIrq = (stateQ == ST_FIN);
  assign busy    = (stateQ != ST_IDLE);

endmodule

// File: rtl/qdma_dp.sv
module qdma_dp
  import qdma_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 128,
  parameter int          CNT_W    = 16,
  parameter int          REG_AW   = 8,
  parameter logic [31:0] DST_BASE = 32'h2000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [REG_AW-1:0]  cfgAddr,
  input  logic [31:0]        cfgWdata,
  output logic [31:0]        cfgRdata,
  input  logic               busy,
  input  dpStrobe_t          strb,
  output logic               startReq,
  output logic               cntZero,
  output logic               lastBeat,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData
);

  localparam int              BEAT_BYTES = DATA_W / 8;
  localparam int              IDX_W      = REG_AW - 4;
  localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] WIN_BASE  = ADDR_W'(DST_BASE);

  logic [31:0]        ctrlQ;
  logic [CNT_W-1:0]   countQ;
  logic [ADDR_W-1:0]  srcQ, tgtQ;
  logic [ADDR_W-1:0]  rdPtrQ, wrPtrQ;
  logic [CNT_W-1:0]   remainQ;
  logic [DATA_W-1:0]  bufQ;
  logic [IDX_W-1:0]   cfgIdx;
  logic               cfgTake;

  assign cfgIdx   = cfgAddr[REG_AW-1:4];
  assign cfgTake  = cfgWe && !busy;
  assign startReq = cfgTake && (cfgIdx == IDX_W'(REG_CTRL)) && cfgWdata[START_BIT];

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      countQ <= '0;
      srcQ   <= '0;
      tgtQ   <= '0;
    end else if (strb.finish) begin
      countQ           <= '0;
      ctrlQ[START_BIT] <= 1'b0;
    end else if (cfgTake) begin
      case (cfgIdx)
        IDX_W'(REG_CTRL):  ctrlQ  <= cfgWdata;
        IDX_W'(REG_COUNT): countQ <= cfgWdata[CNT_W-1:0];
        IDX_W'(REG_SRC):   srcQ   <= cfgWdata[ADDR_W-1:0];
        IDX_W'(REG_TGT):   tgtQ   <= cfgWdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfgIdx)
      IDX_W'(REG_CTRL):  cfgRdata = ctrlQ;
      IDX_W'(REG_COUNT): cfgRdata = 32'(countQ);
      IDX_W'(REG_SRC):   cfgRdata = 32'(srcQ);
      IDX_W'(REG_TGT):   cfgRdata = 32'(tgtQ);
      default:           cfgRdata = '0;
    endcase
  end

  // working pointers, beat counter and quadword buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtrQ  <= '0;
      wrPtrQ  <= '0;
      remainQ <= '0;
      bufQ    <= '0;
    end else begin
      if (strb.load) begin
        rdPtrQ  <= srcQ;
        wrPtrQ  <= WIN_BASE + tgtQ;
        remainQ <= countQ;
      end else if (strb.advance) begin
        rdPtrQ  <= rdPtrQ + BEAT_STEP;
        wrPtrQ  <= wrPtrQ + BEAT_STEP;
        remainQ <= remainQ - 1'b1;
      end
      if (strb.capture) bufQ <= rdData;
    end
  end

  assign cntZero  = (countQ == '0);
  assign lastBeat = (remainQ == CNT_W'(1));
  assign rdAddr   = rdPtrQ;
  assign wrAddr   = wrPtrQ;
  assign wrData   = bufQ;

endmodule

// File: rtl/qcopy_dma.sv
module qcopy_dma
  import qdma_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 128,
  parameter int          CNT_W    = 16,
  parameter int          REG_AW   = 8,
  parameter logic [31:0] DST_BASE = 32'h2000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [REG_AW-1:0]  cfgAddr,
  input  logic [31:0]        cfgWdata,
  output logic [31:0]        cfgRdata,
  output logic               rdReq,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic               rdReady,
  input  logic [DATA_W-1:0]  rdData,
  output logic               wrReq,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  input  logic               wrReady,
  output logic               doneIrq
);

  dpStrobe_t strb;
  logic      busy, startReq, cntZero, lastBeat;

  qdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cntZero(cntZero),
    .lastBeat(lastBeat), .rdReady(rdReady), .wrReady(wrReady),
    .rdReq(rdReq), .wrReq(wrReq), .doneIrq(doneIrq), .busy(busy), .strb(strb)
  );

  qdma_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .REG_AW(REG_AW), .DST_BASE(DST_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .busy(busy), .strb(strb),
    .startReq(startReq), .cntZero(cntZero), .lastBeat(lastBeat),
    .rdAddr(rdAddr), .rdData(rdData), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/qcopy_dma_chk.sv
module qcopy_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic              rdReady,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              wrReq,
  input logic              wrReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              doneIrq
);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdReady) |=> (rdReq && $stable(rdAddr)));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrReady) |=> (wrReq && $stable(wrAddr) && $stable(wrData)));

  // R4
  beat_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdReady) |=> (wrReq && (wrData == $past(rdData))));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> (!rdReq && !wrReq));

endmodule

bind qcopy_dma qcopy_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdReady(rdReady), .rdAddr(rdAddr),
  .rdData(rdData), .wrReq(wrReq), .wrReady(wrReady), .wrAddr(wrAddr),
  .wrData(wrData), .doneIrq(doneIrq)
);

// File: tb/qcopy_dma_tb.sv
module qcopy_dma_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] WIN        = 32'h2000_0000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWe = 1'b0;
  logic [7:0]   cfgAddr = '0;
  logic [31:0]  cfgWdata = '0;
  logic [31:0]  cfgRdata;
  logic         rdReq, wrReq, doneIrq;
  logic [31:0]  rdAddr, wrAddr;
  logic         rdReady = 1'b0, wrReady = 1'b0;
  logic [127:0] rdData, wrData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] srcWord(input logic [31:0] a);
    return {a ^ 32'h5A5A_0F0F, ~a, a * 32'd3, a + 32'h1234_5678};
  endfunction

  assign rdData = srcWord(rdAddr);

  qcopy_dma #(.DST_BASE(WIN)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdReady(rdReady), .rdData(rdData), .wrReq(wrReq),
    .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady), .doneIrq(doneIrq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgAddr = '0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdata;
    cfgAddr = '0;
  endtask

  task automatic runCopy(input int n, input logic [31:0] src, input logic [31:0] tgt,
                         input logic [31:0] ctrlLow, input int pct);
    int  rdIdx = 0, wrIdx = 0;
    bit  sawIrq = 0, lastFinal;
    logic [31:0] v, ea;
    cfgWrite(8'h10, n);
    cfgWrite(8'h20, src);
    cfgWrite(8'h30, tgt);
    cfgWrite(8'h00, ctrlLow | 32'h100);
    lastFinal = (n == 0);
    for (int cyc = 0; cyc < 4000 && !sawIrq; cyc++) begin
      if (doneIrq) begin
        sawIrq = 1;
        cfgWe = 1'b0; cfgAddr = '0; rdReady = 1'b0; wrReady = 1'b0;
        // R6 R7: irq exactly one cycle after the last write, all beats done
        chk(lastFinal && rdIdx == n && wrIdx == n, (n == 0) ? "R7" : "R6",
            "irq timing/beat count", 128'(wrIdx), 128'(n));
      end else begin
        if (!cfgWe) begin
          // R8: start bit reads as busy
          v = cfgRdata;
          chk(v[8] == 1'b1, "R8", "busy start bit", 128'(v), 128'(v | 32'h100));
        end
        lastFinal = 0;
        rdReady = ($urandom % 100) < pct;
        wrReady = ($urandom % 100) < pct;
        if (rdReq && wrReq) chk(0, "R4", "both requests", 128'(1), 128'(0));
        if (rdReq && rdReady) begin
          ea = src + 32'(16 * rdIdx);
          chk(rdAddr == ea && rdIdx == wrIdx, "R4", "read address", 128'(rdAddr), 128'(ea));
          rdIdx++;
        end
        if (wrReq && wrReady) begin
          ea = WIN + tgt + 32'(16 * wrIdx);
          chk(wrAddr == ea, "R4", "write address", 128'(wrAddr), 128'(ea));
          chk(wrData == srcWord(src + 32'(16 * wrIdx)), "R4", "write data",
              wrData, srcWord(src + 32'(16 * wrIdx)));
          wrIdx++;
          if (wrIdx == n) lastFinal = 1;
        end
        // R8: mid-copy writes to every register must be dropped
        case (cyc)
          1: begin cfgWe = 1'b1; cfgAddr = 8'h10; cfgWdata = 32'h0000_0007; end
          2: begin cfgWe = 1'b1; cfgAddr = 8'h20; cfgWdata = ~src; end
          3: begin cfgWe = 1'b1; cfgAddr = 8'h30; cfgWdata = ~tgt; end
          4: begin cfgWe = 1'b1; cfgAddr = 8'h00; cfgWdata = 32'h0; end
          default: begin cfgWe = 1'b0; cfgAddr = '0; end
        endcase
      end
      @(negedge clk);
    end
    if (!sawIrq) chk(0, "R6", "watchdog: no completion", 128'(0), 128'(1));
    chk(doneIrq == 1'b0, "R6", "irq pulse width", 128'(doneIrq), 128'(0));
    cfgRead(8'h10, v); chk(v == 0, "R6", "count cleared", 128'(v), 128'(0));
    cfgRead(8'h00, v);
    chk(v == (ctrlLow & ~32'h100), "R6", "control after copy", 128'(v), 128'(ctrlLow & ~32'h100));
    cfgRead(8'h20, v); chk(v == src, "R9", "source kept", 128'(v), 128'(src));
    cfgRead(8'h30, v); chk(v == tgt, "R9", "target kept", 128'(v), 128'(tgt));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      cfgRead(8'(i * 16), v);
      chk(v == 0, "R1", "register after reset", 128'(v), 128'(0));
    end
    chk(!rdReq && !wrReq && !doneIrq, "R1", "outputs after reset",
        128'({rdReq, wrReq, doneIrq}), 128'(0));

    // R2: offset decode, low bits ignored, high indices unmapped
    cfgWrite(8'h2C, 32'hCAFE_0010);
    cfgRead(8'h20, v); chk(v == 32'hCAFE_0010, "R2", "src via offset 0x2C", 128'(v), 128'(32'hCAFE_0010));
    cfgWrite(8'h33, 32'h0000_0400);
    cfgRead(8'h3F, v); chk(v == 32'h0000_0400, "R2", "tgt via offset 0x33", 128'(v), 128'(32'h400));
    cfgWrite(8'h50, 32'hFFFF_FFFF);
    cfgRead(8'h50, v); chk(v == 0, "R2", "unmapped index", 128'(v), 128'(0));
    cfgRead(8'h10, v); chk(v == 0, "R2", "count untouched by unmapped write", 128'(v), 128'(0));

    // R3: control write without start only stores
    cfgWrite(8'h10, 32'd3);
    cfgWrite(8'h00, 32'h0000_00F3);
    for (int i = 0; i < 5; i++) begin
      chk(!rdReq && !wrReq && !doneIrq, "R3", "no traffic without start",
          128'({rdReq, wrReq, doneIrq}), 128'(0));
      @(negedge clk);
    end
    cfgRead(8'h00, v); chk(v == 32'h0000_00F3, "R3", "control stored", 128'(v), 128'(32'hF3));

    // directed corners
    runCopy(0, 32'h0000_1000, 32'h0000_0200, 32'h0000_0021, 100);  // R7
    runCopy(1, 32'h0000_3000, 32'h0000_0040, 32'h8000_0001, 100);  // R4 single beat
    runCopy(4, 32'hFFFF_FFE0, 32'h0000_0000, 32'h0000_0000, 100);  // R4 address wrap
    runCopy(6, 32'h0001_0008, 32'h0000_1230, 32'h0000_F000, 15);   // R5 long stalls

    // constrained random copies
    for (int t = 0; t < 25; t++) begin
      runCopy(int'($urandom % 13), $urandom, $urandom & 32'h0FFF_FFFF,
              $urandom & ~32'h100, 20 + int'($urandom % 81));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule